// File: doc/BRIEF.md
# Atomic Sequence Interrupt Gate

This block decides, at each instruction boundary of a small CPU, whether a pending event is taken and which one. There are three kinds of source. Maskable interrupt lines each carry a priority level, and a peripheral transfer request is simply one more such line. Ordinary traps are held off by an atomic lock. Severe-fault traps are never held off. An interrupt line is eligible only when its level is strictly above the current CPU level. Traps of either kind ignore that level.

An atomic command retires together with a lock count. The boundary at the atomic instruction itself is closed at once. The instructions that follow, up to the count, then run as one unbroken group. The boundary after the last of them is open again. A severe-fault trap may still break into the group, and taking it throws away the rest of the lock. Requests are levels: whatever is held off stays pending and is taken at the first open boundary, until the requester sees the accept and drops its request.

The decision is made in the cycle in which the retire strobe is high. The accept pulse, event class and source index appear one clock later. The lock status reflects the lock counter register.

Top module: `atomic_irq_gate`

## Requirements
- R1: An interrupt line is taken only if its priority is strictly greater than `cpu_level_i`. An equal priority is not taken.
- R2: A trap request of either kind is taken regardless of `cpu_level_i`.
- R3: An atomic command retiring with count N locks the next N retired instructions. The boundary at the atomic instruction itself is closed, and `lock_o` is high from the following cycle.
- R4: While a boundary is closed, interrupt lines and ordinary traps are not taken.
- R5: A severe-fault trap is taken even at a closed boundary, and taking it clears the lock so that `lock_o` is low in the following cycle.
- R6: Nothing is taken in a cycle whose retire strobe is low. `take_o` is high only in the cycle after a retire.
- R7: Class priority is severe-fault trap, then ordinary trap, then interrupt. `take_class_o` encodes these as 3, 2 and 1, and 0 means nothing taken. Within one trap kind, the lowest set bit index wins.
- R8: Among eligible interrupt lines the highest priority wins, and on a tie the lowest line index wins. `take_id_o` gives the line index.
- R9: Only retire strobes count. The lock state is unchanged over any cycles without a retire, however long an instruction runs.
- R10: The lock count decreases by one per retire of a locked instruction. The boundary at the retire of the Nth locked instruction is open.
- R11: A lock count of 0 is treated as 1, and a count above `MAX_LOCK` is treated as `MAX_LOCK` (4 by default).
- R12: A request held off at closed boundaries is taken at the first open boundary, provided it is still asserted.
- R13: During and after reset, `take_o`, `take_class_o`, `take_id_o` and `lock_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | An instruction completes this cycle (a boundary) |
| atomic_i | input | 1 | The retiring instruction is an atomic command |
| atomic_cnt_i | input | CNT_W | Lock count carried by the atomic command |
| cpu_level_i | input | PRIO_W | Current CPU priority level |
| irq_req_i | input | NUM_IRQ | Interrupt request levels |
| irq_prio_i | input | NUM_IRQ*PRIO_W | Packed priority per line, line i at bits i*PRIO_W upward |
| trap_a_i | input | NUM_TA | Ordinary trap requests, maskable by the lock |
| trap_b_i | input | NUM_TB | Severe-fault trap requests, never masked |
| take_o | output | 1 | An event was taken at the previous boundary |
| take_class_o | output | 2 | Class of taken event: 0 none, 1 interrupt, 2 ordinary trap, 3 severe trap |
| take_id_o | output | ID_W | Source index within the class |
| lock_o | output | 1 | Locked instructions remain |

## Verification
Every result is registered once. The accept pulse, class and index for a boundary appear exactly one clock after the cycle in which the retire strobe was high, and the lock status changes in that same next cycle. The bench drives all inputs at the falling edge and computes the expected result of that cycle from its own model of the lock counter. It then compares the outputs at the next falling edge, one full rising edge later. Cycles without a retire are checked in the same way, so a result that comes early or late, or a lock that moves between retires, is a mismatch at that sample.

// File: rtl/aig_pkg.sv
package aig_pkg;

   typedef enum logic [1:0] {
      CLS_NONE  = 2'd0,
      CLS_IRQ   = 2'd1,
      CLS_TRAPA = 2'd2,
      CLS_TRAPB = 2'd3
   } ev_class_e;

   function automatic int unsigned idx_bits(int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/aig_first_set.sv
module aig_first_set #(
   parameter int N    = 4,
   parameter int ID_W = 2
) (
   input  logic [N-1:0]    req_i,
   output logic            valid_o,
   output logic [ID_W-1:0] id_o
);

   generate
      if (N == 1) begin : g_single
         assign valid_o = req_i[0];
         assign id_o    = '0;
      end else begin : g_scan
         always_comb begin
            valid_o = 1'b0;
            id_o    = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req_i[i]) begin
                  valid_o = 1'b1;
                  id_o    = ID_W'(i);
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/aig_irq_arb.sv
module aig_irq_arb #(
   parameter int NUM_IRQ = 8,
   parameter int PRIO_W  = 4,
   parameter int ID_W    = 3
) (
   input  logic [NUM_IRQ-1:0]        req_i,
   input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
   input  logic [PRIO_W-1:0]         level_i,
   output logic                      valid_o,
   output logic [ID_W-1:0]           id_o,
   output logic [PRIO_W-1:0]         prio_o
);

   logic [PRIO_W-1:0] line_prio [NUM_IRQ];

   generate
      for (genvar g = 0; g < NUM_IRQ; g++) begin : g_unpack
         assign line_prio[g] = prio_i[g*PRIO_W +: PRIO_W];
      end
   endgenerate

   // strict compare keeps the lowest index on equal priority
   always_comb begin
      valid_o = 1'b0;
      id_o    = '0;
      prio_o  = '0;
      for (int i = 0; i < NUM_IRQ; i++) begin
         if (req_i[i] && (line_prio[i] > level_i) &&
             (!valid_o || (line_prio[i] > prio_o))) begin
            valid_o = 1'b1;
            id_o    = ID_W'(i);
            prio_o  = line_prio[i];
         end
      end
   end

endmodule

// File: rtl/aig_lock_ctr.sv
module aig_lock_ctr #(
   parameter int MAX_LOCK = 4,
   parameter int CNT_W    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             retire_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_cnt_i,
   input  logic             clear_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             mask_o
);

   localparam logic [CNT_W-1:0] MAXV = CNT_W'(MAX_LOCK);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_val;

   always_comb begin
      if (load_cnt_i == '0)
         load_val = ONE;
      else if (load_cnt_i > MAXV)
         load_val = MAXV;
      else
         load_val = load_cnt_i;
   end

   // closed at the atomic itself and at every locked retire but the last
   assign mask_o = load_i | (cnt_q > ONE);
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (retire_i) begin
         if (clear_i)
            cnt_q <= '0;
         else if (load_i)
            cnt_q <= load_val;
         else if (cnt_q != '0)
            cnt_q <= cnt_q - ONE;
      end
   end

   // R9
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !retire_i |=> $stable(cnt_q));
   // R11
   lock_load_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retire_i && load_i && !clear_i |=> (cnt_q != '0) && (cnt_q <= MAXV));
   // R5
   lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retire_i && clear_i |=> cnt_q == '0);
   // R10
   lock_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retire_i && !load_i && !clear_i && (cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE);

endmodule

// File: rtl/atomic_irq_gate.sv
module atomic_irq_gate
   import aig_pkg::*;
#(
   parameter int NUM_IRQ  = 8,
   parameter int PRIO_W   = 4,
   parameter int NUM_TA   = 3,
   parameter int NUM_TB   = 3,
   parameter int MAX_LOCK = 4,
   parameter int CNT_W    = $clog2(MAX_LOCK + 1),
   parameter int ID_W     = idx_bits(max3(NUM_IRQ, NUM_TA, NUM_TB))
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      retire_i,
   input  logic                      atomic_i,
   input  logic [CNT_W-1:0]          atomic_cnt_i,
   input  logic [PRIO_W-1:0]         cpu_level_i,
   input  logic [NUM_IRQ-1:0]        irq_req_i,
   input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio_i,
   input  logic [NUM_TA-1:0]         trap_a_i,
   input  logic [NUM_TB-1:0]         trap_b_i,
   output logic                      take_o,
   output logic [1:0]                take_class_o,
   output logic [ID_W-1:0]           take_id_o,
   output logic                      lock_o
);

   generate
      if (NUM_IRQ < 1 || NUM_TA < 1 || NUM_TB < 1 || PRIO_W < 1) begin : g_bad_size
         $error("atomic_irq_gate: every source count and PRIO_W must be at least 1");
      end
      if (MAX_LOCK < 1 || CNT_W < $clog2(MAX_LOCK + 1)) begin : g_bad_lock
         $error("atomic_irq_gate: MAX_LOCK must be at least 1 and fit in CNT_W");
      end
      if ((1 << ID_W) < max3(NUM_IRQ, NUM_TA, NUM_TB)) begin : g_bad_id
         $error("atomic_irq_gate: ID_W too narrow for the source counts");
      end
   endgenerate

   logic              irq_v, ta_v, tb_v, mask;
   logic [ID_W-1:0]   irq_id, ta_id, tb_id;
   logic [PRIO_W-1:0] irq_prio;
   logic [CNT_W-1:0]  lock_cnt;

   aig_irq_arb #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
      .req_i   (irq_req_i),
      .prio_i  (irq_prio_i),
      .level_i (cpu_level_i),
      .valid_o (irq_v),
      .id_o    (irq_id),
      .prio_o  (irq_prio)
   );

   aig_first_set #(.N(NUM_TA), .ID_W(ID_W)) u_trap_a (
      .req_i (trap_a_i), .valid_o (ta_v), .id_o (ta_id)
   );

   aig_first_set #(.N(NUM_TB), .ID_W(ID_W)) u_trap_b (
      .req_i (trap_b_i), .valid_o (tb_v), .id_o (tb_id)
   );

   aig_lock_ctr #(.MAX_LOCK(MAX_LOCK), .CNT_W(CNT_W)) u_lock (
      .clk        (clk),
      .rst_n      (rst_n),
      .retire_i   (retire_i),
      .load_i     (atomic_i),
      .load_cnt_i (atomic_cnt_i),
      .clear_i    (tb_v),
      .cnt_o      (lock_cnt),
      .mask_o     (mask)
   );

   ev_class_e       pick_cls;
   logic [ID_W-1:0] pick_id;

   always_comb begin
      pick_cls = CLS_NONE;
      pick_id  = '0;
      if (retire_i) begin
         if (tb_v) begin
            pick_cls = CLS_TRAPB;
            pick_id  = tb_id;
         end else if (!mask && ta_v) begin
            pick_cls = CLS_TRAPA;
            pick_id  = ta_id;
         end else if (!mask && irq_v) begin
            pick_cls = CLS_IRQ;
            pick_id  = irq_id;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         take_o       <= 1'b0;
         take_class_o <= CLS_NONE;
         take_id_o    <= '0;
      end else begin
         take_o       <= (pick_cls != CLS_NONE);
         take_class_o <= pick_cls;
         take_id_o    <= pick_id;
      end
   end

   assign lock_o = (lock_cnt != '0);

   // R1
   irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_o && (take_class_o == CLS_IRQ) |-> $past(irq_prio) > $past(cpu_level_i));
   // R2
   trap_a_any_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retire_i && !mask && (|trap_a_i) && !(|trap_b_i) |=> take_o && (take_class_o == CLS_TRAPA));
   // R4
   masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_o && ((take_class_o == CLS_IRQ) || (take_class_o == CLS_TRAPA)) |-> !$past(mask));
   // R3
   atomic_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retire_i && atomic_i && !(|trap_b_i) |=> lock_o && (take_class_o != CLS_IRQ) && (take_class_o != CLS_TRAPA));
   // R5
   trap_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retire_i && (|trap_b_i) |=> take_o && (take_class_o == CLS_TRAPB) && !lock_o);
   // R6
   no_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !retire_i |=> !take_o);
   // R7
   class_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_o == (take_class_o != CLS_NONE));

endmodule

// File: tb/sim_atomic_irq_gate.sv
module sim_atomic_irq_gate;

   localparam int CLK_PERIOD = 10;
   localparam int NI = 8;
   localparam int PW = 4;
   localparam int NA = 3;
   localparam int NB = 3;
   localparam int ML = 4;
   localparam int CW = 3;
   localparam int IW = 3;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              retire, atomic;
   logic [CW-1:0]     acnt;
   logic [PW-1:0]     level;
   logic [NI-1:0]     irq;
   logic [NI*PW-1:0]  prio;
   logic [NA-1:0]     ta;
   logic [NB-1:0]     tb;
   logic              take, lock;
   logic [1:0]        cls;
   logic [IW-1:0]     id;

   int n_chk  = 0;
   int n_fail = 0;
   int m_cnt  = 0;
   int e_take, e_cls, e_id, e_lock;
   bit finished = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   atomic_irq_gate #(
      .NUM_IRQ(NI), .PRIO_W(PW), .NUM_TA(NA), .NUM_TB(NB),
      .MAX_LOCK(ML), .CNT_W(CW), .ID_W(IW)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .retire_i(retire), .atomic_i(atomic),
      .atomic_cnt_i(acnt), .cpu_level_i(level), .irq_req_i(irq),
      .irq_prio_i(prio), .trap_a_i(ta), .trap_b_i(tb),
      .take_o(take), .take_class_o(cls), .take_id_o(id), .lock_o(lock)
   );

   task automatic chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int lowest(logic [7:0] v);
      for (int i = 0; i < 8; i++) if (v[i]) return i;
      return -1;
   endfunction

   // spec model: decision for the current inputs, lock count update
   task automatic model();
      bit mask;
      int best, bp, p;
      mask   = atomic || (m_cnt > 1);
      e_take = 0; e_cls = 0; e_id = 0;
      if (retire) begin
         if (tb != 0) begin
            e_take = 1; e_cls = 3; e_id = lowest(8'(tb)); m_cnt = 0;
         end else begin
            if (!mask && ta != 0) begin
               e_take = 1; e_cls = 2; e_id = lowest(8'(ta));
            end else if (!mask) begin
               best = -1; bp = -1;
               for (int i = 0; i < NI; i++) begin
                  p = int'(prio[i*PW +: PW]);
                  if (irq[i] && p > int'(level) && p > bp) begin
                     best = i; bp = p;
                  end
               end
               if (best >= 0) begin
                  e_take = 1; e_cls = 1; e_id = best;
               end
            end
            if (atomic)
               m_cnt = (acnt == 0) ? 1 : ((int'(acnt) > ML) ? ML : int'(acnt));
            else if (m_cnt > 0)
               m_cnt--;
         end
      end
      e_lock = (m_cnt != 0) ? 1 : 0;
   endtask

   task automatic tick(string tag);
      model();
      @(negedge clk);
      chk(tag, "take", int'(take), e_take);
      chk(tag, "class", int'(cls), e_cls);
      if (e_take != 0) chk(tag, "id", int'(id), e_id);
      chk(tag, "lock", int'(lock), e_lock);
   endtask

   task automatic idle();
      retire = 1'b0; atomic = 1'b0; acnt = '0; level = '0;
      irq = '0; prio = '0; ta = '0; tb = '0;
   endtask

   task automatic set_prio(int line, int v);
      prio[line*PW +: PW] = PW'(v);
   endtask

   initial begin
      idle();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R13 reset state
      chk("R13", "take", int'(take), 0);
      chk("R13", "class", int'(cls), 0);
      chk("R13", "id", int'(id), 0);
      chk("R13", "lock", int'(lock), 0);
      rst_n = 1'b1;
      tick("R13");

      // R1 strict level compare
      level = 4'd5; irq = 8'b0000_0100; set_prio(2, 5); retire = 1'b1;
      tick("R1");
      set_prio(2, 6);
      tick("R1");

      // R2 traps ignore level
      idle(); level = 4'd15; ta = 3'b010; retire = 1'b1;
      tick("R2");

      // R8 highest priority, lowest index on tie
      idle(); retire = 1'b1; irq = 8'b0010_1010;
      set_prio(1, 7); set_prio(3, 3); set_prio(5, 7);
      tick("R8");
      irq[6] = 1'b1; set_prio(6, 9);
      tick("R8");

      // R7 class order
      tb = 3'b110; ta = 3'b100;
      tick("R7");
      tb = '0;
      tick("R7");

      // R3 R4 R9 R10 R12: lock of two with held requests
      idle(); irq = 8'b0001_0000; set_prio(4, 12); ta = 3'b001;
      retire = 1'b1; atomic = 1'b1; acnt = 3'd2;
      tick("R3");
      atomic = 1'b0;
      tick("R4");
      retire = 1'b0;
      repeat (3) tick("R9");
      retire = 1'b1;
      tick("R10");
      ta = '0;
      tick("R12");

      // R11 count 0 acts as 1, count 7 acts as MAX_LOCK
      atomic = 1'b1; acnt = 3'd0;
      tick("R11");
      atomic = 1'b0;
      tick("R11");
      atomic = 1'b1; acnt = 3'd7;
      tick("R11");
      atomic = 1'b0;
      for (int k = 0; k < 4; k++) tick("R11");

      // R5 severe trap breaks the lock
      atomic = 1'b1; acnt = 3'd4;
      tick("R5");
      atomic = 1'b0;
      tick("R5");
      tb = 3'b001;
      tick("R5");
      tb = '0;
      tick("R5");

      // R6 no retire, no take
      retire = 1'b0; tb = 3'b100; ta = 3'b001;
      tick("R6");
      tb = '0; ta = '0;

      // constrained random
      void'($urandom(32'd1234));
      for (int n = 0; n < 4000; n++) begin
         retire = ($urandom_range(0, 9) < 7);
         atomic = ($urandom_range(0, 9) == 0);
         acnt   = CW'($urandom_range(0, 7));
         level  = PW'($urandom_range(0, 15));
         irq    = NI'($urandom) & NI'($urandom);
         prio   = (NI*PW)'($urandom);
         ta     = ($urandom_range(0, 9) == 0) ? NA'($urandom_range(1, 7)) : '0;
         tb     = ($urandom_range(0, 24) == 0) ? NB'($urandom_range(1, 7)) : '0;
         tick("R6_R7_R8_R10");
      end

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

endmodule